// File: doc/BRIEF.md
# DMA Channel Register Front End

This block holds the software-visible control and interrupt registers for a bank of DMA channel pairs. It sits on a 32-bit register bus. Each pair holds one write-direction channel and one read-direction channel. The descriptor engine lives outside the block and sees the registers as plain outputs: enable, linked-list mode, cycle bits, the 64-bit list pointer and a one-cycle start pulse. The engine reports back through a two-bit run state and per-channel stop and abort event strobes.

The block latches stop and abort events into sticky per-channel interrupt status bits. Software clears these bits through a separate write-one-to-clear register. Each channel drives its own interrupt line, which is qualified by mask bits and local enable bits. Writes take effect on the clock edge that samples them. Read data is combinational from the address, with no read strobe. There is no back-pressure: every register access completes in one cycle, so no valid/ready handshake is needed.

Top module: `dma_chan_regfile`

## Requirements
- R1: After reset every register reads zero, and every output is zero: irq lines, start pulses, enables, cycle bits, list pointers and link mode.
- R2: Address map and indexing:
  - Pair p sits at byte offset p*0x200. Its write channel is at +0x000 and its read channel at +0x100, so channel index = 2*p + direction.
  - The list pointer low word (0x10) and high word (0x14) read back in full and drive the 64-bit pointer output.
  - Cycle sync (0x18) bits [1:0] (bit 0 consumer cycle, bit 1 cycle status) read back and drive the cycle output.
  - Control (0x34) bit 0 reads back and drives linked-list mode.
- R3: Writing 1 in bit 0 of the doorbell (0x04) makes that channel's start output high for exactly the one cycle after the write. Writing 0 in bit 0 gives no pulse. The doorbell reads zero.
- R4: Enable (0x00) bit 0 is writable, reads back, and drives the channel enable output. Its other bits read zero.
- R5: Status (0x80) bits [1:0] return the engine's run state (1 running, 3 finished, any other value error). Writes to status are ignored.
- R6: Interrupt status (0x84) bit 0 is set by a stop event and bit 2 by an abort event. Both bits stay set until cleared. Writes to 0x84 are ignored.
- R7: Writing 1 to bit 0 or bit 2 of interrupt clear (0x8C) clears the matching status bit. The clear register reads zero.
- R8: When an event and a clear hit the same status bit in one cycle, the bit ends set.
- R9: Interrupt setup (0x88) bits 0 (stop mask), 2 (abort mask) and 3..6 (remote stop, local stop, remote abort, local abort enables) are writable. Bit 1 and bits above 6 read zero.
- R10: A channel's irq is (stop status AND NOT stop mask AND local stop enable) OR (abort status AND NOT abort mask AND local abort enable). The remote enables do not affect irq.
- R11: Reads of undefined offsets, of offsets that are not word-aligned, and of pairs at or above NUM_PAIRS return zero. Writes to them are ignored.
- R12: A write to one channel leaves every other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| run_state | input | 2*NCH | Engine run state, two bits per channel |
| stop_evt | input | NCH | Stop (done) event strobe per channel |
| abort_evt | input | NCH | Abort event strobe per channel |
| ch_enable | output | NCH | Channel enable bits |
| ch_start | output | NCH | One-cycle start pulse per channel |
| ch_linked | output | NCH | Linked-list mode per channel |
| ch_cycle | output | 2*NCH | Consumer cycle bit and cycle status per channel |
| ch_list_ptr | output | 64*NCH | List pointer per channel |
| ch_irq | output | NCH | Interrupt line per channel |

## Verification
The assertions assume a rising irq is always preceded by an event strobe or a register write. They also assume that start pulses come only from doorbell writes. Both hold only if the engine inputs change solely through stop and abort strobes. The stimulus therefore drives events as one-cycle strobes between bus accesses. The one exception is a deliberate collision of an event with a clear. The stimulus also keeps reg_addr inside the 12-bit window, so the zero-read rule for unimplemented pairs can be checked against a plain address bound.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;
  localparam int REG_W = 32;
  localparam logic [7:0] OFF_ENABLE   = 8'h00;
  localparam logic [7:0] OFF_DOORBELL = 8'h04;
  localparam logic [7:0] OFF_LPTR_LO  = 8'h10;
  localparam logic [7:0] OFF_LPTR_HI  = 8'h14;
  localparam logic [7:0] OFF_CYCLE    = 8'h18;
  localparam logic [7:0] OFF_CONTROL  = 8'h34;
  localparam logic [7:0] OFF_STATUS   = 8'h80;
  localparam logic [7:0] OFF_INT_STAT = 8'h84;
  localparam logic [7:0] OFF_INT_SET  = 8'h88;
  localparam logic [7:0] OFF_INT_CLR  = 8'h8C;
  // writable bits of interrupt setup: masks 0,2 and enables 3..6
  localparam logic [6:0] SETUP_WMASK  = 7'b111_1101;

  typedef struct packed {
    logic       loc_abort_en;
    logic       rem_abort_en;
    logic       loc_stop_en;
    logic       rem_stop_en;
    logic       abort_mask;
    logic       rsvd;
    logic       stop_mask;
  } int_setup_t;
endpackage

// File: rtl/dmacr_decode.sv
module dmacr_decode
  import dmacr_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter int ADDR_W    = 12,
  localparam int NCH      = 2 * NUM_PAIRS,
  localparam int IDX_W    = ADDR_W - 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NCH-1:0]    sel,
  output logic [7:0]        off
);
  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_W-1:8];
  assign off = addr[7:0];

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(c);
    assign sel[c] = (idx == MY_IDX);
  end
endmodule

// File: rtl/dmacr_chan.sv
module dmacr_chan
  import dmacr_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [7:0]    off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [1:0]    run_state,
  input  logic          stop_evt,
  input  logic          abort_evt,
  output logic          enable,
  output logic          start,
  output logic          linked,
  output logic [1:0]    cycle,
  output logic [63:0]   list_ptr,
  output logic          irq
);
  int_setup_t setup_q;
  logic       stop_st, abort_st;
  logic       wr_hit, clr_hit;

  assign wr_hit  = wr && sel;
  assign clr_hit = wr_hit && (off == OFF_INT_CLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable   <= 1'b0;
      start    <= 1'b0;
      linked   <= 1'b0;
      cycle    <= 2'b00;
      list_ptr <= '0;
      setup_q  <= '0;
      stop_st  <= 1'b0;
      abort_st <= 1'b0;
    end else begin
      start <= wr_hit && (off == OFF_DOORBELL) && wdata[0];
      if (wr_hit) begin
        case (off)
          OFF_ENABLE:  enable          <= wdata[0];
          OFF_LPTR_LO: list_ptr[31:0]  <= wdata[31:0];
          OFF_LPTR_HI: list_ptr[63:32] <= wdata[31:0];
          OFF_CYCLE:   cycle           <= wdata[1:0];
          OFF_CONTROL: linked          <= wdata[0];
          OFF_INT_SET: setup_q         <= int_setup_t'(wdata[6:0] & SETUP_WMASK);
          default: ;
        endcase
      end
      // event wins over a simultaneous clear
      stop_st  <= stop_evt  | (stop_st  & ~(clr_hit & wdata[0]));
      abort_st <= abort_evt | (abort_st & ~(clr_hit & wdata[2]));
    end
  end

  assign irq = (stop_st  & ~setup_q.stop_mask  & setup_q.loc_stop_en) |
               (abort_st & ~setup_q.abort_mask & setup_q.loc_abort_en);

  always_comb begin
    rdata = '0;
    if (sel) begin
      case (off)
        OFF_ENABLE:   rdata[0]    = enable;
        OFF_LPTR_LO:  rdata       = list_ptr[31:0];
        OFF_LPTR_HI:  rdata       = list_ptr[63:32];
        OFF_CYCLE:    rdata[1:0]  = cycle;
        OFF_CONTROL:  rdata[0]    = linked;
        OFF_STATUS:   rdata[1:0]  = run_state;
        OFF_INT_STAT: rdata[2:0]  = {abort_st, 1'b0, stop_st};
        OFF_INT_SET:  rdata[6:0]  = setup_q;
        default:      rdata       = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile
  import dmacr_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter int ADDR_W    = 12,
  localparam int NCH      = 2 * NUM_PAIRS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [2*NCH-1:0]  run_state,
  input  logic [NCH-1:0]    stop_evt,
  input  logic [NCH-1:0]    abort_evt,
  output logic [NCH-1:0]    ch_enable,
  output logic [NCH-1:0]    ch_start,
  output logic [NCH-1:0]    ch_linked,
  output logic [2*NCH-1:0]  ch_cycle,
  output logic [64*NCH-1:0] ch_list_ptr,
  output logic [NCH-1:0]    ch_irq
);
  logic [NCH-1:0]   sel;
  logic [7:0]       off;
  logic [REG_W-1:0] rd_ch [NCH];

  dmacr_decode #(.NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W)) u_dec (
    .addr(reg_addr), .sel(sel), .off(off)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dmacr_chan #(.DW(REG_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel[c]),
      .wr        (reg_wr),
      .off       (off),
      .wdata     (reg_wdata),
      .rdata     (rd_ch[c]),
      .run_state (run_state[2*c +: 2]),
      .stop_evt  (stop_evt[c]),
      .abort_evt (abort_evt[c]),
      .enable    (ch_enable[c]),
      .start     (ch_start[c]),
      .linked    (ch_linked[c]),
      .cycle     (ch_cycle[2*c +: 2]),
      .list_ptr  (ch_list_ptr[64*c +: 64]),
      .irq       (ch_irq[c])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NCH; c++) reg_rdata = reg_rdata | rd_ch[c];
  end
endmodule

// File: rtl/dma_chan_regfile_chk.sv
module dma_chan_regfile_chk #(
  parameter int NUM_PAIRS = 2,
  parameter int ADDR_W    = 12,
  localparam int NCH      = 2 * NUM_PAIRS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [NCH-1:0]    stop_evt,
  input logic [NCH-1:0]    abort_evt,
  input logic [NCH-1:0]    ch_enable,
  input logic [NCH-1:0]    ch_start,
  input logic [NCH-1:0]    ch_linked,
  input logic [NCH-1:0]    ch_irq
);
  localparam int LIMIT = NUM_PAIRS * 512;

  // R11
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) >= LIMIT) |-> (reg_rdata == 32'h0));

  // R4
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(ch_enable));

  // R2
  linked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(ch_linked));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    localparam logic [ADDR_W-1:0] DB_ADDR = ADDR_W'(c * 256 + 4);

    // R3
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_start[c] |-> $past(reg_wr && (reg_addr == DB_ADDR) && reg_wdata[0]));

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_irq[c]) |-> $past(stop_evt[c] || abort_evt[c] || reg_wr));
  end
endmodule

bind dma_chan_regfile dma_chan_regfile_chk #(.NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stop_evt(stop_evt),
  .abort_evt(abort_evt), .ch_enable(ch_enable), .ch_start(ch_start),
  .ch_linked(ch_linked), .ch_irq(ch_irq)
);

// File: tb/test_dma_chan_regfile.sv
`timescale 1ns/1ps
module test_dma_chan_regfile;
  localparam int NP = 2;
  localparam int NCH = 2 * NP;
  localparam int AW = 12;
  localparam int NV = 22;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [AW-1:0]     reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [2*NCH-1:0]  run_state = '0;
  logic [NCH-1:0]    stop_evt = '0;
  logic [NCH-1:0]    abort_evt = '0;
  logic [NCH-1:0]    ch_enable, ch_start, ch_linked, ch_irq;
  logic [2*NCH-1:0]  ch_cycle;
  logic [64*NCH-1:0] ch_list_ptr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_chan_regfile #(.NUM_PAIRS(NP), .ADDR_W(AW)) i_dma_chan_regfile (.*);

  // {req[3:0], is_write, addr[11:0], data[31:0]}; for reads data is the expectation
  localparam logic [48:0] VEC [NV] = '{
    {4'd4,  1'b1, 12'h000, 32'hFFFF_FFFF},  // R4
    {4'd4,  1'b0, 12'h000, 32'h0000_0001},  // R4
    {4'd2,  1'b1, 12'h010, 32'h1234_ABCD},  // R2
    {4'd2,  1'b0, 12'h010, 32'h1234_ABCD},  // R2
    {4'd2,  1'b1, 12'h114, 32'hCAFE_0001},  // R2
    {4'd2,  1'b0, 12'h114, 32'hCAFE_0001},  // R2
    {4'd12, 1'b0, 12'h014, 32'h0000_0000},  // R12
    {4'd2,  1'b1, 12'h218, 32'h0000_00FF},  // R2
    {4'd2,  1'b0, 12'h218, 32'h0000_0003},  // R2
    {4'd2,  1'b1, 12'h334, 32'h0000_000F},  // R2
    {4'd2,  1'b0, 12'h334, 32'h0000_0001},  // R2
    {4'd9,  1'b1, 12'h088, 32'hFFFF_FFFF},  // R9
    {4'd9,  1'b0, 12'h088, 32'h0000_007D},  // R9
    {4'd3,  1'b1, 12'h004, 32'h0000_0000},  // R3
    {4'd3,  1'b0, 12'h004, 32'h0000_0000},  // R3
    {4'd11, 1'b1, 12'h040, 32'h0000_0005},  // R11
    {4'd11, 1'b0, 12'h040, 32'h0000_0000},  // R11
    {4'd11, 1'b1, 12'h400, 32'h0000_0001},  // R11
    {4'd11, 1'b0, 12'h400, 32'h0000_0000},  // R11
    {4'd7,  1'b0, 12'h08C, 32'h0000_0000},  // R7
    {4'd11, 1'b0, 12'h012, 32'h0000_0000},  // R11
    {4'd12, 1'b0, 12'h100, 32'h0000_0000}   // R12
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(string req, logic [AW-1:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic pulse_stop(int c);
    @(negedge clk); stop_evt[c] = 1'b1;
    @(negedge clk); stop_evt[c] = 1'b0;
  endtask

  task automatic pulse_abort(int c);
    @(negedge clk); abort_evt[c] = 1'b1;
    @(negedge clk); abort_evt[c] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1", 12'h000, 0);
    rd("R1", 12'h088, 0);
    rd("R1", 12'h184, 0);
    check("R1", 64'({ch_irq, ch_start, ch_enable, ch_linked}), 64'h0);
    check("R1", 64'({ch_cycle, ch_list_ptr[63:0]}), 64'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44]) wr(VEC[i][43:32], VEC[i][31:0]);
      else rd($sformatf("R%0d", VEC[i][48:45]), VEC[i][43:32], VEC[i][31:0]);
    end

    // R4 / R2 outputs after table
    check("R4", 64'(ch_enable), 64'b0001);
    check("R2", ch_list_ptr[63:0], 64'h0000_0000_1234_ABCD);
    check("R2", ch_list_ptr[127:64], 64'hCAFE_0001_0000_0000);
    check("R2", 64'(ch_linked), 64'b1000);
    check("R2", 64'(ch_cycle[5:4]), 64'd3);
    check("R3", 64'(ch_start), 64'h0);

    // R3 doorbell pulse on channel 1
    wr(12'h104, 32'h1);
    check("R3", 64'(ch_start), 64'b0010);
    @(negedge clk);
    check("R3", 64'(ch_start), 64'b0000);

    // R5 run state
    run_state[1:0] = 2'd1;
    rd("R5", 12'h080, 1);
    run_state[1:0] = 2'd3;
    rd("R5", 12'h080, 3);
    run_state[7:6] = 2'd2;
    rd("R5", 12'h380, 2);
    wr(12'h080, 32'h0);
    rd("R5", 12'h080, 3);

    // R10 local enables, masks clear
    wr(12'h088, 32'h50);
    pulse_stop(0);
    rd("R6", 12'h084, 1);
    check("R10", 64'(ch_irq), 64'b0001);
    wr(12'h088, 32'h51);
    check("R10", 64'(ch_irq), 64'b0000);
    wr(12'h088, 32'h28);
    check("R10", 64'(ch_irq), 64'b0000);
    // R7 clear stop
    wr(12'h08C, 32'h1);
    rd("R7", 12'h084, 0);
    // R6 abort sticky, writes ignored
    pulse_abort(0);
    rd("R6", 12'h084, 4);
    wr(12'h084, 32'h0);
    rd("R6", 12'h084, 4);
    wr(12'h088, 32'h40);
    check("R10", 64'(ch_irq), 64'b0001);
    wr(12'h088, 32'h44);
    check("R10", 64'(ch_irq), 64'b0000);
    wr(12'h08C, 32'h4);
    rd("R7", 12'h084, 0);
    // R8 set wins over clear
    @(negedge clk);
    stop_evt[0] = 1'b1;
    reg_wr = 1'b1; reg_addr = 12'h08C; reg_wdata = 32'h5;
    @(negedge clk);
    stop_evt[0] = 1'b0; reg_wr = 1'b0;
    rd("R8", 12'h084, 1);
    // R12 other channels untouched by ch0 events
    rd("R12", 12'h184, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule